// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is a bus master that moves the bytes of a configuration item into system memory without the host reading them one at a time through a data port. The host writes the 64-bit address of a 16-byte descriptor into a pointer register. The engine then reads the descriptor from memory. The descriptor holds a 64-bit target address, a 32-bit length and a 32-bit control word, each stored big-endian. From the control word the engine can switch to a new configuration item. It then either copies item bytes to the target address or skips over them. When it is done it writes a status word over the descriptor's control field.

The engine does not hold the configuration items. It works through a small item port that it shares with the byte-wide data port: it can request a new selection, it reads the current item's length, offset and the byte at that offset, and it can advance the shared offset by a step count. The memory side is a single request/response master. It issues big-endian 32-bit word reads and writes for the descriptor and single-byte writes for payload data.

Top module: `cfgx_dma`

## Requirements
- R1: After reset, `busy`, `mem_req`, `item_sel` and `item_adv` are all 0.
- R2: When `reg_size` is 0/1/2/3, an access is 1/2/4/8 bytes wide. A read at byte offset `reg_off` returns, in the low bits of `reg_rdata`, the bytes of the constant SIG (default 64'h4346474D44413031) at positions `reg_off` to `reg_off`+n-1, where position 0 is the most significant byte. An access that runs past byte 7 returns 0.
- R3: A 4-byte write at offset 0 loads the upper pointer half, clears the lower half and does not start a transfer. A 4-byte write at offset 4 ORs its value into the lower half and starts a transfer at the combined pointer.
- R4: An 8-byte write at offset 0 loads the whole pointer and starts a transfer. A write of any other size or offset starts nothing.
- R5: A transfer first reads four 32-bit words at pointer+0, +4, +8 and +12. These hold the target high half, the target low half, the length and the control word, and each word's lowest-addressed byte is its most significant.
- R6: Control bits are error=bit0, read=bit1, skip=bit2 and select=bit3. When select is set, one `item_sel` pulse carries control[31:16] before any payload access.
- R7: In read mode, each available item byte is written to target+i and is followed by an `item_adv` pulse with step 1, until the length is used up.
- R8: In read mode, once the item is absent or exhausted, the rest of the length is written to memory as zero bytes.
- R9: In skip mode, the engine makes no payload writes. Each step advances the item by min(remaining length, bytes left in the item) with a single `item_adv` pulse. An exhausted or absent item ends the skip at once.
- R10: If neither read nor skip is set, the length counts as zero. If both are set, read mode applies.
- R11: A memory error on any descriptor read, or on a payload write, stops the transfer and makes the status word 1.
- R12: Every transfer ends with one 32-bit write of the status word to pointer+12. The status is 0 on success.
- R13: The stored pointer register reads as zero once a transfer has started, so a later lone low-half write starts at an address whose upper half is zero.
- R14: While `busy` is 1, pointer writes are ignored and cannot start a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Pointer register write strobe |
| reg_off | input | 3 | Byte offset of the register access |
| reg_size | input | 2 | Access size, log2 of the byte count |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature read data, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_wide | output | 1 | 1 for a 32-bit word, 0 for a byte |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write data, byte in bits 7:0 |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_err | input | 1 | Error flag, valid with the acknowledge |
| mem_rdata | input | 32 | Big-endian read word, valid with the acknowledge |
| item_sel | output | 1 | Select pulse, offset returns to 0 |
| item_sel_key | output | KW | Key to select |
| item_adv | output | 1 | Offset advance pulse |
| item_step | output | LW | Advance amount |
| item_present | input | 1 | Current item exists and has data |
| item_len | input | LW | Current item length |
| item_off | input | LW | Current shared offset |
| item_byte | input | 8 | Item byte at the current offset |

## Verification
The bench drives the reads across the end of an item and checks that real bytes stop exactly at the item length and that zeros follow. A design that padded from the wrong byte, or stopped short, leaves target bytes wrong. Skips are counted in advance pulses: an engine that stepped byte by byte, or that overran the item, shows the wrong pulse count, and a read that follows the skip starts at the wrong offset. Errors are injected on a descriptor word and on a middle payload byte. A design that kept going writes bytes past the fault or reports status 0. The pointer tests check that a lone high-half write does not start a transfer, that the pointer is cleared once a transfer begins, and that a write during a busy transfer is dropped.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   localparam int BIT_ERR  = 0;
   localparam int BIT_RD   = 1;
   localparam int BIT_SKIP = 2;
   localparam int BIT_SEL  = 3;
   localparam int KEY_LSB  = 16;

   localparam logic [1:0] SZ_W4 = 2'd2;
   localparam logic [1:0] SZ_W8 = 2'd3;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_SEL,
      S_PLAN,
      S_BYTE,
      S_ADV,
      S_STAT
   } seq_e;
endpackage

// File: rtl/cfgx_ptr.sv
module cfgx_ptr
   import cfgx_pkg::*;
#(
   parameter int          AW  = 64,
   parameter logic [63:0] SIG = 64'h4346_474D_4441_3031
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [2:0]    off,
   input  logic [1:0]    size,
   input  logic [63:0]   wdata,
   input  logic          busy,
   output logic [63:0]   rdata,
   output logic          start,
   output logic [AW-1:0] base,
   output logic [63:0]   ptr_q
);
   logic [63:0] ptr_nxt;
   logic [3:0]  nbytes;
   logic [3:0]  span;
   logic [6:0]  shamt;
   logic [63:0] mask;

   always_comb begin
      start   = 1'b0;
      ptr_nxt = ptr_q;
      if (wr && !busy) begin
         if (size == SZ_W4 && off == 3'd0) begin
            ptr_nxt = {wdata[31:0], 32'h0};
         end else if (size == SZ_W4 && off == 3'd4) begin
            ptr_nxt = ptr_q | {32'h0, wdata[31:0]};
            start   = 1'b1;
         end else if (size == SZ_W8 && off == 3'd0) begin
            ptr_nxt = wdata;
            start   = 1'b1;
         end
      end
   end

   assign base = ptr_nxt[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_q <= '0;
      else if (start) ptr_q <= '0;
      else            ptr_q <= ptr_nxt;
   end

   always_comb begin
      nbytes = 4'd1 << size;
      span   = {1'b0, off} + nbytes;
      shamt  = {4'd8 - span, 3'b000};
      mask   = (nbytes == 4'd8) ? '1 : ((64'd1 << {nbytes, 3'b000}) - 64'd1);
      if (span > 4'd8) rdata = '0;
      else             rdata = (SIG >> shamt) & mask;
   end
endmodule

// File: rtl/cfgx_chunk.sv
module cfgx_chunk #(
   parameter int LW = 32
) (
   input  logic [LW-1:0] rem,
   input  logic          present,
   input  logic [LW-1:0] len,
   input  logic [LW-1:0] off,
   output logic          have,
   output logic [LW-1:0] chunk
);
   logic [LW-1:0] avail;

   assign have  = present && (off < len);
   assign avail = len - off;
   assign chunk = (rem < avail) ? rem : avail;
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
   import cfgx_pkg::*;
#(
   parameter int AW = 64,
   parameter int LW = 32,
   parameter int KW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] base,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_wide,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic          mem_err,
   input  logic [31:0]   mem_rdata,
   output logic          item_sel,
   output logic [KW-1:0] item_sel_key,
   output logic          item_adv,
   output logic [LW-1:0] item_step,
   input  logic [7:0]    item_byte,
   input  logic          have,
   input  logic [LW-1:0] chunk,
   output logic [LW-1:0] rem
);
   seq_e          st;
   logic [AW-1:0] base_q, tgt_q;
   logic [31:0]   thi_q;
   logic [63:0]   tgt_full;
   logic [LW-1:0] rem_q, step_q;
   logic [KW-1:0] key_q;
   logic [1:0]    fidx;
   logic [7:0]    byte_q;
   logic          rd_mode, err_q, from_item;

   assign tgt_full = {thi_q, mem_rdata};
   assign rem      = rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         base_q    <= '0;
         tgt_q     <= '0;
         thi_q     <= '0;
         rem_q     <= '0;
         step_q    <= '0;
         key_q     <= '0;
         fidx      <= '0;
         byte_q    <= '0;
         rd_mode   <= 1'b0;
         err_q     <= 1'b0;
         from_item <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               base_q <= base;
               fidx   <= '0;
               err_q  <= 1'b0;
               st     <= S_FETCH;
            end
            S_FETCH: if (mem_ack) begin
               if (mem_err) begin
                  err_q <= 1'b1;
                  st    <= S_STAT;
               end else begin
                  fidx <= fidx + 2'd1;
                  case (fidx)
                     2'd0: thi_q <= mem_rdata;
                     2'd1: tgt_q <= tgt_full[AW-1:0];
                     2'd2: rem_q <= mem_rdata[LW-1:0];
                     default: begin
                        rd_mode <= mem_rdata[BIT_RD];
                        key_q   <= mem_rdata[KEY_LSB +: KW];
                        if (!(mem_rdata[BIT_RD] || mem_rdata[BIT_SKIP])) rem_q <= '0;
                        st <= mem_rdata[BIT_SEL] ? S_SEL : S_PLAN;
                     end
                  endcase
               end
            end
            S_SEL: st <= S_PLAN;
            S_PLAN: begin
               if (rem_q == '0) begin
                  st <= S_STAT;
               end else if (have) begin
                  if (rd_mode) begin
                     byte_q    <= item_byte;
                     from_item <= 1'b1;
                     st        <= S_BYTE;
                  end else begin
                     step_q <= chunk;
                     rem_q  <= rem_q - chunk;
                     st     <= S_ADV;
                  end
               end else if (rd_mode) begin
                  byte_q    <= 8'h00;
                  from_item <= 1'b0;
                  st        <= S_BYTE;
               end else begin
                  rem_q <= '0;
                  st    <= S_STAT;
               end
            end
            S_BYTE: if (mem_ack) begin
               if (mem_err) begin
                  err_q <= 1'b1;
                  st    <= S_STAT;
               end else begin
                  rem_q <= rem_q - 1'b1;
                  tgt_q <= tgt_q + 1'b1;
                  if (from_item) begin
                     step_q <= LW'(1);
                     st     <= S_ADV;
                  end else begin
                     st <= S_PLAN;
                  end
               end
            end
            S_ADV:  st <= S_PLAN;
            S_STAT: if (mem_ack) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy      = (st != S_IDLE);
   assign mem_req   = (st == S_FETCH) || (st == S_BYTE) || (st == S_STAT);
   assign mem_we    = (st == S_BYTE) || (st == S_STAT);
   assign mem_wide  = (st != S_BYTE);
   assign item_sel  = (st == S_SEL);
   assign item_adv  = (st == S_ADV);
   assign item_step = step_q;
   assign item_sel_key = key_q;

   always_comb begin
      mem_addr  = '0;
      mem_wdata = '0;
      case (st)
         S_FETCH: mem_addr = base_q + AW'({fidx, 2'b00});
         S_BYTE: begin
            mem_addr  = tgt_q;
            mem_wdata = {24'h0, byte_q};
         end
         S_STAT: begin
            mem_addr  = base_q + AW'(12);
            mem_wdata = {31'h0, err_q};
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cfgx_dma.sv
module cfgx_dma
   import cfgx_pkg::*;
#(
   parameter int          AW  = 64,
   parameter int          LW  = 32,
   parameter int          KW  = 16,
   parameter logic [63:0] SIG = 64'h4346_474D_4441_3031
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [2:0]    reg_off,
   input  logic [1:0]    reg_size,
   input  logic [63:0]   reg_wdata,
   output logic [63:0]   reg_rdata,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_wide,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic          mem_err,
   input  logic [31:0]   mem_rdata,
   output logic          item_sel,
   output logic [KW-1:0] item_sel_key,
   output logic          item_adv,
   output logic [LW-1:0] item_step,
   input  logic          item_present,
   input  logic [LW-1:0] item_len,
   input  logic [LW-1:0] item_off,
   input  logic [7:0]    item_byte
);
   generate
      if (AW < 33 || AW > 64) begin : g_bad_aw
         $error("cfgx_dma: AW must lie in 33..64");
      end
      if (LW < 1 || LW > 32) begin : g_bad_lw
         $error("cfgx_dma: LW must lie in 1..32");
      end
      if (KW < 1 || KW > 16) begin : g_bad_kw
         $error("cfgx_dma: KW must lie in 1..16");
      end
   endgenerate

   logic          start;
   logic [AW-1:0] base;
   logic [63:0]   ptr_q;
   logic          have;
   logic [LW-1:0] chunk, rem;

   cfgx_ptr #(.AW(AW), .SIG(SIG)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .off(reg_off), .size(reg_size),
      .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata), .start(start),
      .base(base), .ptr_q(ptr_q)
   );

   cfgx_chunk #(.LW(LW)) u_chunk (
      .rem(rem), .present(item_present), .len(item_len), .off(item_off),
      .have(have), .chunk(chunk)
   );

   cfgx_seq #(.AW(AW), .LW(LW), .KW(KW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_err(mem_err), .mem_rdata(mem_rdata), .item_sel(item_sel),
      .item_sel_key(item_sel_key), .item_adv(item_adv), .item_step(item_step),
      .item_byte(item_byte), .have(have), .chunk(chunk), .rem(rem)
   );
endmodule

// File: rtl/cfgx_dma_chk.sv
module cfgx_dma_chk #(
   parameter int AW = 64,
   parameter int LW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_wide,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          mem_ack,
   input logic          item_sel,
   input logic          item_adv,
   input logic [LW-1:0] item_step,
   input logic [63:0]   ptr_q
);
   // R1: the reset state is idle, with nothing driven
   a_r1_idle_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !busy && !mem_req && !item_sel && !item_adv);

   // R5: a request is held steady until it is acknowledged
   a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wide));

   // R6: select and advance pulses come only during a transfer, never together, never with a memory access
   a_r6_item_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      (item_sel || item_adv) |-> busy && !mem_req && !(item_sel && item_adv));

   // R9: an advance always moves the offset
   a_r9_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      item_adv |-> item_step != '0);

   // R12: word writes carry only the status value 0 or 1
   a_r12_status_value: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_wide |-> mem_wdata[31:1] == 31'h0);

   // R12: a transfer ends only after its status write is acknowledged
   a_r12_end_on_status: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_ack && mem_we && mem_wide));

   // R13: the stored pointer is zero once a transfer has begun
   a_r13_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ptr_q == 64'h0);
endmodule

bind cfgx_dma cfgx_dma_chk #(.AW(AW), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
   .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_ack(mem_ack), .item_sel(item_sel), .item_adv(item_adv),
   .item_step(item_step), .ptr_q(u_ptr.ptr_q)
);

// File: tb/sim_cfgx_dma.sv
module sim_cfgx_dma;
   localparam logic [63:0] SIGV = 64'h4346_474D_4441_3031;
   localparam int D = 'h100;
   localparam int T = 'h200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_off = '0;
   logic [1:0]  reg_size = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        busy, mem_req, mem_we, mem_wide;
   logic [63:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        item_sel, item_adv;
   logic [15:0] item_sel_key;
   logic [31:0] item_step;
   logic        item_present;
   logic [31:0] item_len, item_off;
   logic [7:0]  item_byte;

   logic [7:0]  mem [0:1023];
   logic [63:0] err_addr = '1;
   int          rd_cnt = 0, bw_cnt = 0, sel_cnt = 0, adv_cnt = 0;
   logic [63:0] rd_log [0:63];
   logic [63:0] st_addr = '0;
   logic [31:0] st_data = '0;
   logic [15:0] ikey = '0, last_key = '0;
   logic [31:0] ioff = '0;
   int          tests = 0, fails = 0;

   always #5 clk = ~clk;

   cfgx_dma u0 (.*);

   // memory model: acknowledge one cycle after a request
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_addr == err_addr) begin
            mem_err <= 1'b1;
         end else if (mem_we && mem_wide) begin
            for (int k = 0; k < 4; k++) mem[mem_addr[9:0] + 10'(k)] <= mem_wdata[31-8*k -: 8];
            st_addr <= mem_addr;
            st_data <= mem_wdata;
         end else if (mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata[7:0];
            bw_cnt <= bw_cnt + 1;
         end else begin
            mem_rdata <= {mem[mem_addr[9:0]], mem[mem_addr[9:0]+10'd1],
                          mem[mem_addr[9:0]+10'd2], mem[mem_addr[9:0]+10'd3]};
            rd_log[rd_cnt[5:0]] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   // item store: key 1 has 5 bytes, key 2 has 3, others absent
   always @(posedge clk) begin
      if (!rst_n) begin
         ikey <= '0;
         ioff <= '0;
      end else if (item_sel) begin
         ikey     <= item_sel_key;
         last_key <= item_sel_key;
         ioff     <= '0;
         sel_cnt  <= sel_cnt + 1;
      end else if (item_adv) begin
         ioff    <= ioff + item_step;
         adv_cnt <= adv_cnt + 1;
      end
   end
   assign item_present = (ikey == 16'd1) || (ikey == 16'd2);
   assign item_len     = (ikey == 16'd1) ? 32'd5 : (ikey == 16'd2) ? 32'd3 : 32'd0;
   assign item_off     = ioff;
   assign item_byte    = 8'(ikey * 16) + ioff[7:0] + 8'h01;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put_desc(input int b, input logic [63:0] tgt, input logic [31:0] len, input logic [31:0] ctl);
      logic [127:0] d = {tgt, len, ctl};
      for (int k = 0; k < 16; k++) mem[b + k] = d[127-8*k -: 8];
   endtask

   task automatic fill(input int a, input int n, input logic [7:0] v);
      for (int k = 0; k < n; k++) mem[a + k] = v;
   endtask

   task automatic reg_write(input logic [2:0] off, input logic [1:0] sz, input logic [63:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_off = off; reg_size = sz; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
   endtask

   function automatic logic [31:0] ctlw(input int key, input int bits);
      return {16'(key), 16'(bits)};
   endfunction

   function automatic logic [31:0] word_at(input int a);
      return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
   endfunction

   task automatic t_reset();
      chk(!busy && !mem_req && !item_sel && !item_adv, "R1 reset idle",
          {busy, mem_req, item_sel, item_adv}, 0);
   endtask

   task automatic t_signature();
      @(negedge clk); reg_off = 0; reg_size = 3; #1;
      chk(reg_rdata == SIGV, "R2 sig 8@0", reg_rdata, SIGV);
      reg_off = 4; reg_size = 2; #1;
      chk(reg_rdata == 64'h4441_3031, "R2 sig 4@4", reg_rdata, 64'h44413031);
      reg_off = 6; reg_size = 1; #1;
      chk(reg_rdata == 64'h3031, "R2 sig 2@6", reg_rdata, 64'h3031);
      reg_off = 1; reg_size = 0; #1;
      chk(reg_rdata == 64'h46, "R2 sig 1@1", reg_rdata, 64'h46);
      reg_off = 6; reg_size = 2; #1;
      chk(reg_rdata == 64'h0, "R2 sig past end", reg_rdata, 0);
   endtask

   task automatic t_copy();
      int r0 = rd_cnt, s0 = sel_cnt, a0 = adv_cnt;
      fill(T, 8, 8'hEE);
      put_desc(D, T, 5, ctlw(1, 'hA));
      reg_write(0, 3, D);
      chk(busy, "R4 8-byte write starts", busy, 1);
      wait_idle();
      chk(rd_cnt - r0 == 4 && rd_log[r0[5:0]] == D, "R5 four fetch reads at pointer",
          rd_log[r0[5:0]], D);
      chk(sel_cnt - s0 == 1 && last_key == 1, "R6 select key", last_key, 1);
      for (int k = 0; k < 5; k++)
         chk(mem[T+k] == 8'h11 + 8'(k), "R7 copied byte", mem[T+k], 8'h11 + 8'(k));
      chk(mem[T+5] == 8'hEE, "R7 length bound", mem[T+5], 8'hEE);
      chk(adv_cnt - a0 == 5, "R7 step per byte", adv_cnt - a0, 5);
      chk(st_addr == D + 12 && word_at(D+12) == 0, "R12 status zero at +12",
          {st_addr[31:0], word_at(D+12)}, {32'(D+12), 32'h0});
   endtask

   task automatic t_zero_fill();
      fill(T, 8, 8'hFF);
      put_desc(D, T, 6, ctlw(2, 'hA));
      reg_write(0, 3, D);
      wait_idle();
      for (int k = 0; k < 3; k++)
         chk(mem[T+k] == 8'h21 + 8'(k), "R8 data before end", mem[T+k], 8'h21 + 8'(k));
      for (int k = 3; k < 6; k++)
         chk(mem[T+k] == 8'h00, "R8 zero past end", mem[T+k], 0);
      chk(mem[T+6] == 8'hFF, "R8 fill bound", mem[T+6], 8'hFF);
      fill(T, 4, 8'hFF);
      put_desc(D, T, 3, ctlw(7, 'hA));
      reg_write(0, 3, D);
      wait_idle();
      chk(word_at(T) == 32'h0000_00FF, "R8 absent item zeros", word_at(T), 32'h000000FF);
   endtask

   task automatic t_skip();
      int b0 = bw_cnt, a0 = adv_cnt;
      put_desc(D, T, 2, ctlw(1, 'hC));
      reg_write(0, 3, D);
      wait_idle();
      chk(bw_cnt == b0 && adv_cnt - a0 == 1, "R9 skip single step no write",
          {32'(bw_cnt - b0), 32'(adv_cnt - a0)}, {32'h0, 32'h1});
      fill(T, 4, 8'hEE);
      put_desc(D, T, 3, ctlw(0, 'h2));
      reg_write(0, 3, D);
      wait_idle();
      chk(word_at(T) == 32'h1314_15EE, "R9 read resumes after skip", word_at(T), 32'h131415EE);
      b0 = bw_cnt; a0 = adv_cnt;
      put_desc(D, T, 10, ctlw(0, 'h4));
      reg_write(0, 3, D);
      wait_idle();
      chk(bw_cnt == b0 && adv_cnt == a0 && word_at(D+12) == 0, "R9 skip past end completes",
          {32'(adv_cnt - a0), word_at(D+12)}, 0);
      a0 = adv_cnt;
      put_desc(D, T, 9, ctlw(1, 'hC));
      reg_write(0, 3, D);
      wait_idle();
      chk(adv_cnt - a0 == 1, "R9 skip clipped to item", adv_cnt - a0, 1);
   endtask

   task automatic t_modes();
      int b0 = bw_cnt;
      put_desc(D, T, 4, ctlw(1, 'h8));
      reg_write(0, 3, D);
      wait_idle();
      chk(bw_cnt == b0 && word_at(D+12) == 0, "R10 no mode means zero length",
          bw_cnt - b0, 0);
      fill(T, 4, 8'hEE);
      put_desc(D, T, 2, ctlw(1, 'hE));
      reg_write(0, 3, D);
      wait_idle();
      chk(word_at(T) == 32'h1112_EEEE, "R10 read beats skip", word_at(T), 32'h1112EEEE);
   endtask

   task automatic t_errors();
      int b0 = bw_cnt;
      put_desc(D, T, 4, ctlw(1, 'hA));
      err_addr = D + 8;
      reg_write(0, 3, D);
      wait_idle();
      chk(bw_cnt == b0 && word_at(D+12) == 1, "R11 fetch error status",
          word_at(D+12), 1);
      fill(T, 4, 8'hEE);
      put_desc(D, T, 4, ctlw(1, 'hA));
      err_addr = T + 1;
      reg_write(0, 3, D);
      wait_idle();
      err_addr = '1;
      chk(word_at(T) == 32'h11EE_EEEE && word_at(D+12) == 1, "R11 data error stops",
          {word_at(T), word_at(D+12)}, {32'h11EEEEEE, 32'h1});
   endtask

   task automatic t_pointer();
      int r0;
      put_desc(D, T, 1, ctlw(1, 'hA));
      reg_write(0, 2, 64'h3);
      repeat (2) @(negedge clk);
      chk(!busy, "R3 high half alone does not start", busy, 0);
      r0 = rd_cnt;
      reg_write(4, 2, D);
      chk(busy, "R3 low half starts", busy, 1);
      wait_idle();
      chk(rd_log[r0[5:0]] == 64'h3_0000_0100, "R3 combined pointer",
          rd_log[r0[5:0]], 64'h300000100);
      chk(st_addr == 64'h3_0000_010C, "R12 status at pointer+12", st_addr, 64'h30000010C);
      r0 = rd_cnt;
      reg_write(4, 2, D);
      wait_idle();
      chk(rd_log[r0[5:0]] == 64'(D), "R13 pointer cleared at start", rd_log[r0[5:0]], D);
   endtask

   task automatic t_ignored();
      int r0 = rd_cnt;
      reg_write(2, 2, D);
      reg_write(0, 1, D);
      reg_write(4, 3, D);
      reg_write(4, 0, D);
      repeat (3) @(negedge clk);
      chk(!busy && rd_cnt == r0, "R4 other writes ignored", rd_cnt - r0, 0);
   endtask

   task automatic t_busy_block();
      int r0 = rd_cnt;
      put_desc(D, T, 4, ctlw(1, 'hA));
      put_desc('h180, T, 4, ctlw(2, 'hA));
      reg_write(0, 3, D);
      reg_write(0, 3, 'h180);
      wait_idle();
      repeat (20) @(negedge clk);
      chk(rd_cnt - r0 == 4 && !busy, "R14 write while busy dropped", rd_cnt - r0, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_signature();
      t_copy();
      t_zero_fill();
      t_skip();
      t_modes();
      t_errors();
      t_pointer();
      t_ignored();
      t_busy_block();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule